// File: doc/BRIEF.md
# Byte-Stream Quadlet Packer

This block sits between a byte-wide application source and the transmit buffer of a serial-bus link layer. On every rising edge of the application clock it may take one 8-bit byte, qualified by a valid strobe. A sync marker that comes with a valid byte opens a new application packet. Bytes are collected four at a time into 32-bit quadlets, and each finished quadlet is written to the downstream buffer as a single-cycle strobe. The strobe carries a first flag, a last flag and a count of the bytes that are meaningful in it.

Packets whose length is a multiple of four need no end marker. A shorter tail is closed by the end marker, which forces out a partial quadlet with the unused byte lanes zeroed. Byte order within a quadlet is big-endian by default. A little-endian choice is taken from a mode pin while reset is held. Flow control uses a ready output driven from the buffer's free-entry count. Because the source reacts to ready one cycle late, the packer always absorbs a valid byte, even on the cycle ready falls. If a sync arrives while a quadlet is only partly filled, the partial bytes are dropped, a sticky framing-error flag is raised, and a new packet starts.

Top module: `byte_quad_packer`

## Requirements
- R1: After reset, out_valid and framing_err are 0 and no packet is open.
- R2: In big-endian mode (le_mode_pin low during reset) the first byte of a quadlet lands in out_quad[31:24] and the fourth in [7:0]. The quadlet is presented with out_valid high and out_nbytes = 4 in the cycle after the clock edge that takes the fourth byte.
- R3: In little-endian mode (le_mode_pin high while rst_n is low) the first byte of a quadlet lands in out_quad[7:0] and the fourth in [31:24].
- R4: out_first is 1 only on the first quadlet emitted after a sync byte, and 0 on every later quadlet of that packet.
- R5: A byte taken with in_end high while the quadlet holds 1 to 3 bytes emits that quadlet at once with out_last = 1, out_nbytes equal to the byte count, and the unused lanes zero.
- R6: A byte taken with in_end high as the fourth byte emits a quadlet with out_last = 1 and out_nbytes = 4. Quadlets not closed by in_end have out_last = 0.
- R7: Cycles with in_valid low take no byte, whatever in_data, in_sync and in_end carry.
- R8: Valid bytes that arrive with no packet open (before any sync, or after an end marker) are discarded and produce no quadlet.
- R9: A sync that arrives while a quadlet holds 1 to 3 bytes discards those bytes, sets framing_err, and starts a new packet whose first quadlet has out_first = 1. framing_err stays set until reset. A sync at a quadlet boundary does not set it.
- R10: in_ready is low exactly when buf_free is below 2. A valid byte offered in the cycle ready goes low is still taken.
- R11: out_valid is high for exactly one cycle per emitted quadlet, and never without a byte having been taken on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| le_mode_pin | input | 1 | Little-endian select, sampled while rst_n is low |
| in_data | input | 8 | Stream byte, bit 7 most significant |
| in_valid | input | 1 | Byte qualifier |
| in_sync | input | 1 | First byte of a packet (with in_valid) |
| in_end | input | 1 | Last byte of a packet (with in_valid) |
| buf_free | input | 4 | Free entries in the downstream quadlet buffer |
| in_ready | output | 1 | Flow control to the source, one-cycle pipelined meaning |
| out_quad | output | 32 | Assembled quadlet |
| out_valid | output | 1 | One-cycle write strobe for out_quad |
| out_first | output | 1 | Quadlet is the first of its packet |
| out_last | output | 1 | Quadlet was closed by the end marker |
| out_nbytes | output | 3 | Meaningful bytes in out_quad (1 to 4) |
| framing_err | output | 1 | Sticky: a sync cut a partial quadlet |

## Verification
The hardest case to reach is a sync that lands in the middle of a partly filled quadlet. The dropped bytes must leave no trace in any output, and the new packet must still be flagged as first. The bench reaches it by opening a packet, feeding two bytes and then a second sync, and then it completes the new packet. It also makes a sync land on an exact quadlet boundary, to show that the flag stays clear there. A second hard point is the pipelined ready. The bench lowers buf_free in the same cycle it offers a byte and checks that the byte still shows up in the next quadlet.

// File: rtl/bqp_pkg.sv
package bqp_pkg;
    localparam int BQP_BYTE_W  = 8;
    localparam int BQP_LANES   = 4;
    localparam int BQP_FREE_W  = 4;
    localparam int BQP_MIN_FREE = 2;
endpackage

// File: rtl/bqp_lane_insert.sv
module bqp_lane_insert #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int QW     = BYTE_W * LANES,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [QW-1:0]     base,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [LANE_W-1:0] lane,
    input  logic              le,
    input  logic              clr,
    output logic [QW-1:0]     word
);
    // Each slot k of the word either takes the new byte or keeps its old content.
    for (genvar k = 0; k < LANES; k++) begin : g_slot
        logic [LANE_W-1:0] be_lane;
        logic              hit;
        assign be_lane = LANE_W'(LANES - 1 - k);
        assign hit     = le ? (lane == LANE_W'(k)) : (lane == be_lane);
        assign word[k*BYTE_W +: BYTE_W] = hit ? byte_in
                                         : (clr ? '0 : base[k*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/bqp_ready_gen.sv
module bqp_ready_gen #(
    parameter int FREE_W   = 4,
    parameter int MIN_FREE = 2
) (
    input  logic [FREE_W-1:0] free_cnt,
    output logic              ready
);
    always_comb begin
        ready = (free_cnt >= FREE_W'(MIN_FREE));
    end
endmodule

// File: rtl/byte_quad_packer.sv
module byte_quad_packer
    import bqp_pkg::*;
#(
    parameter int BYTE_W   = BQP_BYTE_W,
    parameter int LANES    = BQP_LANES,
    parameter int FREE_W   = BQP_FREE_W,
    parameter int MIN_FREE = BQP_MIN_FREE,
    localparam int QW      = BYTE_W * LANES,
    localparam int LANE_W  = $clog2(LANES),
    localparam int CNT_W   = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_mode_pin,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic              in_end,
    input  logic [FREE_W-1:0] buf_free,
    output logic              in_ready,
    output logic [QW-1:0]     out_quad,
    output logic              out_valid,
    output logic              out_first,
    output logic              out_last,
    output logic [CNT_W-1:0]  out_nbytes,
    output logic              framing_err
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [QW-1:0]     acc;
        logic [LANE_W-1:0] lane;
        logic              in_pkt;
        logic              first_pend;
        logic              err;
        logic              ov;
        logic [QW-1:0]     oq;
        logic              of;
        logic              ol;
        logic [CNT_W-1:0]  on;
    } pk_state_t;

    pk_state_t         st_d, st_q;
    logic              le_q;
    logic [LANE_W-1:0] lane_sel;
    logic [QW-1:0]     ins_word;

    // Endian choice is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= le_mode_pin;
    end

    bqp_ready_gen #(.FREE_W(FREE_W), .MIN_FREE(MIN_FREE)) u_ready (
        .free_cnt (buf_free),
        .ready    (in_ready)
    );

    assign lane_sel = in_sync ? '0 : st_q.lane;

    bqp_lane_insert #(.BYTE_W(BYTE_W), .LANES(LANES)) u_ins (
        .base    (st_q.acc),
        .byte_in (in_data),
        .lane    (lane_sel),
        .le      (le_q),
        .clr     (in_sync),
        .word    (ins_word)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.of = 1'b0;
        st_d.ol = 1'b0;
        if (in_valid) begin
            if (in_sync) begin
                if (st_q.in_pkt && (st_q.lane != '0)) st_d.err = 1'b1;
                st_d.in_pkt     = 1'b1;
                st_d.first_pend = 1'b1;
            end
            if (in_sync || st_q.in_pkt) begin
                if ((lane_sel == LAST_LANE) || in_end) begin
                    st_d.ov         = 1'b1;
                    st_d.oq         = ins_word;
                    st_d.of         = st_d.first_pend;
                    st_d.ol         = in_end;
                    st_d.on         = CNT_W'(lane_sel) + CNT_W'(1);
                    st_d.acc        = '0;
                    st_d.lane       = '0;
                    st_d.first_pend = 1'b0;
                    if (in_end) st_d.in_pkt = 1'b0;
                end else begin
                    st_d.acc  = ins_word;
                    st_d.lane = lane_sel + LANE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_quad    = st_q.oq;
    assign out_valid   = st_q.ov;
    assign out_first   = st_q.of;
    assign out_last    = st_q.ol;
    assign out_nbytes  = st_q.on;
    assign framing_err = st_q.err;

    // R11: a strobe always follows an edge that took a byte
    a_r11_strobe_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R6: a quadlet not closed by the end marker is always full
    a_r6_full_unless_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_nbytes == CNT_W'(LANES)));

    // R9: framing error is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        framing_err |=> framing_err);

    // R5: a single-byte big-endian tail has zeroed lower lanes
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_nbytes == CNT_W'(1)) && !le_q) |-> (out_quad[QW-BYTE_W-1:0] == '0));

    // R5: the byte count is never zero on a strobe
    a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nbytes != '0));
endmodule

// File: tb/tb_byte_quad_packer.sv
module tb_byte_quad_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        le_mode_pin = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0, in_sync = 1'b0, in_end = 1'b0;
    logic [3:0]  buf_free = 4'd8;
    logic        in_ready;
    logic [31:0] out_quad;
    logic        out_valid, out_first, out_last, framing_err;
    logic [2:0]  out_nbytes;

    always #10 clk = ~clk;

    byte_quad_packer dut (
        .clk(clk), .rst_n(rst_n), .le_mode_pin(le_mode_pin),
        .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync), .in_end(in_end),
        .buf_free(buf_free), .in_ready(in_ready), .out_quad(out_quad),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
        .out_nbytes(out_nbytes), .framing_err(framing_err)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // reference model state
    byte unsigned mq[$];
    bit m_pkt, m_first, m_err, m_le;
    bit e_v, e_f, e_l;
    logic [31:0] e_q;
    int e_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input bit s, input bit e, input byte unsigned d);
        e_v = 0;
        if (!v) return;
        if (s) begin
            if (m_pkt && mq.size() > 0) m_err = 1;
            mq.delete();
            m_pkt = 1;
            m_first = 1;
        end
        if (!m_pkt) return;
        mq.push_back(d);
        if (mq.size() == 4 || e) begin
            e_q = '0;
            foreach (mq[i]) begin
                if (m_le) e_q[8*i +: 8] = mq[i];
                else      e_q[31-8*i -: 8] = mq[i];
            end
            e_v = 1; e_f = m_first; e_l = e; e_n = mq.size();
            m_first = 0;
            mq.delete();
            if (e) m_pkt = 0;
        end
    endtask

    task automatic compare();
        check(out_valid == e_v, cur_req, "out_valid", out_valid, e_v);
        check(framing_err == m_err, cur_req, "framing_err", framing_err, m_err);
        if (e_v && out_valid) begin
            check(out_quad == e_q, cur_req, "out_quad", out_quad, e_q);
            check(out_first == e_f, cur_req, "out_first (R4)", out_first, e_f);
            check(out_last == e_l, cur_req, "out_last", out_last, e_l);
            check(out_nbytes == 3'(e_n), cur_req, "out_nbytes", out_nbytes, e_n);
        end
    endtask

    task automatic cyc(input bit v, input bit s, input bit e, input byte unsigned d);
        in_valid = v; in_sync = s; in_end = e; in_data = d;
        model(v, s, e, d);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input bit le);
        @(negedge clk);
        rst_n = 0; le_mode_pin = le;
        in_valid = 0; in_sync = 0; in_end = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; le_mode_pin = 0;
        mq.delete(); m_pkt = 0; m_first = 0; m_err = 0; m_le = le; e_v = 0;
    endtask

    task automatic packet(input int len, input bit use_end, input byte unsigned seed);
        for (int i = 0; i < len; i++)
            cyc(1, i == 0, use_end && (i == len - 1), byte'(seed + i));
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset(0);
        cur_req = "R1";
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        check(framing_err == 0, "R1", "framing_err after reset", framing_err, 0);

        // R10 ready threshold
        buf_free = 4'd8; #1;
        check(in_ready == 1, "R10", "ready free=8", in_ready, 1);
        buf_free = 4'd1; #1;
        check(in_ready == 0, "R10", "ready free=1", in_ready, 0);
        buf_free = 4'd2; #1;
        check(in_ready == 1, "R10", "ready free=2", in_ready, 1);
        buf_free = 4'd0; #1;
        check(in_ready == 0, "R10", "ready free=0", in_ready, 0);
        buf_free = 4'd8;

        cur_req = "R2"; packet(8, 0, 8'h10);
        cur_req = "R4"; packet(12, 0, 8'h40);
        cur_req = "R11"; cyc(0, 0, 0, 8'h00); cyc(0, 0, 0, 8'h00);

        // R7: idle cycles carrying junk
        cur_req = "R7";
        cyc(1, 1, 0, 8'hA0); cyc(0, 1, 1, 8'hEE); cyc(1, 0, 0, 8'hA1);
        cyc(0, 0, 1, 8'hDD); cyc(1, 0, 0, 8'hA2); cyc(1, 0, 0, 8'hA3);

        cur_req = "R5";
        packet(6, 1, 8'h60); packet(5, 1, 8'h70); packet(7, 1, 8'h80);
        packet(1, 1, 8'h90); packet(3, 1, 8'h98);
        cur_req = "R6"; packet(4, 1, 8'hB0); packet(8, 1, 8'hC0);

        // R8: bytes with no open packet
        cur_req = "R8";
        cyc(1, 0, 0, 8'h11); cyc(1, 0, 0, 8'h22); cyc(1, 0, 0, 8'h33);
        cyc(1, 0, 1, 8'h44); cyc(1, 0, 0, 8'h55);

        // R9: sync at boundary keeps flag clear, mid-quadlet sync sets it
        cur_req = "R9";
        packet(4, 0, 8'h01);
        cyc(1, 1, 0, 8'h05); cyc(1, 0, 0, 8'h06);
        cyc(1, 1, 0, 8'hD0); cyc(1, 0, 0, 8'hD1); cyc(1, 0, 0, 8'hD2); cyc(1, 0, 0, 8'hD3);
        packet(4, 1, 8'hE0);
        cyc(0, 0, 0, 8'h00);

        // R10: byte offered in the cycle ready falls is still taken
        cur_req = "R10";
        cyc(1, 1, 0, 8'h21); cyc(1, 0, 0, 8'h22);
        buf_free = 4'd1;
        cyc(1, 0, 0, 8'h23);
        check(in_ready == 0, "R10", "ready low while full", in_ready, 0);
        cyc(0, 0, 0, 8'hFF); cyc(0, 0, 0, 8'hFF);
        buf_free = 4'd6;
        cyc(1, 0, 1, 8'h24);
        check(in_ready == 1, "R10", "ready back", in_ready, 1);

        // R3: little-endian selected at reset
        do_reset(1);
        cur_req = "R3";
        packet(4, 0, 8'h31); packet(6, 1, 8'h51); packet(3, 1, 8'h71);
        cyc(0, 0, 0, 8'h00);

        do_reset(0);
        cur_req = "R2"; packet(4, 1, 8'hF0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule